// File: doc/BRIEF.md
# Multi-Source XOR Entropy Harvester

This block takes raw bits from a set of free-running oscillator signals. The oscillators sit outside the block and are not related to its clock. Every oscillator line passes through its own two-flop synchronizer and then into a dedicated capture flop, so that each source is registered on its own before anything combines the sources. The registered values of all sources are folded by one wide XOR. The result is loaded into a single output flop, but only on a sample enable.

The sample enable comes from a programmable down-counter that divides the block clock by K. On every enable the output flop takes a fresh raw bit. One cycle later a valid strobe goes high for one cycle, together with the new bit. The output bit and the strobe form a serial data/strobe pair that an acquisition path or an entropy test can read directly. The number of sources is fixed at compile time. It is chosen so that the oscillator period divided by the jitter accumulated over one sampling period stays below the source count.

Top module: `xor_entropy_harvester`

## Requirements
- R1: While `rst` is high, `ser_valid` and `ser_data` are 0. The first valid strobe appears after the first clock edge at which `rst` is low.
- R2: With `div_k` = K ≥ 2, `ser_valid` is high for exactly one cycle in every K cycles. Rising edges of the strobe are exactly K cycles apart.
- R3: A `div_k` value of 0 is treated as 1, so `ser_valid` stays high on every cycle. K = 1 gives the same behaviour.
- R4: When all `osc_in` lines have been stable for at least four cycles, the bit presented with a strobe equals the XOR of all `osc_in` bits.
- R5: `ser_data` changes only on cycles where `ser_valid` is high. Between strobes it holds its value, even when `osc_in` changes.
- R6: Every source line contributes. Inverting any single `osc_in` bit, with the others held, inverts the next settled `ser_data`.
- R7: A new `div_k` value takes effect only when the current sampling period runs out. The gap that is already counting keeps the old K, and the next gap uses the new K.
- R8: The divider reloads with K−1 on each sample enable and otherwise counts down by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | N_SRC | Asynchronous oscillator lines, one per source |
| div_k | input | KW | Sampling divide factor K (0 behaves as 1) |
| ser_data | output | 1 | Raw random bit |
| ser_valid | output | 1 | One-cycle strobe that marks a new raw bit |

## Verification
The assertions assume that `div_k` stays constant between sample enables, apart from the change that R7 describes. A change of K is checked against the value that was in force at the reload. The data checks assume that the oscillator lines have settled through the synchronizer and the capture stage before the sample they are compared with. The bench therefore never checks a raw bit until at least four cycles after its last `osc_in` change. It changes `div_k` only right after a strobe, and it drives every input one nanosecond after a rising edge, so no line changes near an edge.

// File: rtl/harvest_pkg.sv
package harvest_pkg;
  localparam int unsigned HV_KW_MAX = 32;

  // Divide factor as used by the divider: zero is raised to one.
  function automatic logic [HV_KW_MAX-1:0] clamp_k(input logic [HV_KW_MAX-1:0] k);
    return (k == '0) ? HV_KW_MAX'(1) : k;
  endfunction

  // Reload value for a down-counter that must fire every k cycles.
  function automatic logic [HV_KW_MAX-1:0] reload_of(input logic [HV_KW_MAX-1:0] k);
    return clamp_k(k) - HV_KW_MAX'(1);
  endfunction
endpackage

// File: rtl/osc_capture.sv
module osc_capture #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] osc_in,
  output logic [N_SRC-1:0] cap_q
);
  // One synchronizer pair and one capture flop per source line.
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic meta_q, sync_q, hold_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= osc_in[g];
        sync_q <= meta_q;
        hold_q <= sync_q;
      end
    end
    assign cap_q[g] = hold_q;
  end
endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int unsigned KW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] div_k,
  output logic [KW-1:0] k_eff,
  output logic [KW-1:0] cnt_q,
  output logic          samp_en
);
  import harvest_pkg::*;
  localparam int unsigned PADW = HV_KW_MAX;

  logic [KW-1:0] reload;

  always_comb begin
    k_eff  = KW'(clamp_k(PADW'(div_k)));
    reload = KW'(reload_of(PADW'(div_k)));
  end

  assign samp_en = !rst && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (samp_en) cnt_q <= reload;
    else              cnt_q <= cnt_q - KW'(1);
  end
endmodule

// File: rtl/xor_out_stage.sv
module xor_out_stage #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cap_q,
  input  logic             samp_en,
  output logic             raw_bit,
  output logic             raw_valid
);
  logic folded;
  assign folded = ^cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_bit   <= 1'b0;
      raw_valid <= 1'b0;
    end else begin
      raw_valid <= samp_en;
      if (samp_en) raw_bit <= folded;
    end
  end
endmodule

// File: rtl/xor_entropy_harvester.sv
module xor_entropy_harvester #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned KW    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] osc_in,
  input  logic [KW-1:0]    div_k,
  output logic             ser_data,
  output logic             ser_valid
);
  logic [N_SRC-1:0] cap_q;
  logic [KW-1:0]    k_eff;
  logic [KW-1:0]    cnt_q;
  logic             samp_en;

  osc_capture #(.N_SRC(N_SRC)) u_cap (
    .clk(clk), .rst(rst), .osc_in(osc_in), .cap_q(cap_q)
  );

  rate_divider #(.KW(KW)) u_div (
    .clk(clk), .rst(rst), .div_k(div_k),
    .k_eff(k_eff), .cnt_q(cnt_q), .samp_en(samp_en)
  );

  xor_out_stage #(.N_SRC(N_SRC)) u_out (
    .clk(clk), .rst(rst), .cap_q(cap_q), .samp_en(samp_en),
    .raw_bit(ser_data), .raw_valid(ser_valid)
  );
endmodule

// File: rtl/xor_entropy_harvester_chk.sv
module xor_entropy_harvester_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned KW    = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             samp_en,
  input logic [KW-1:0]    cnt_q,
  input logic [KW-1:0]    k_eff,
  input logic [N_SRC-1:0] cap_q,
  input logic             ser_data,
  input logic             ser_valid
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ser_valid && !ser_data));

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (rst)
    samp_en |=> ser_valid);

  p_no_stray_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> !ser_valid);

  p_sample_fold_r4: assert property (@(posedge clk) disable iff (rst)
    samp_en |=> (ser_data == ^$past(cap_q)));

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> $stable(ser_data));

  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    samp_en |=> (cnt_q == $past(k_eff) - KW'(1)));

  p_countdown_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - KW'(1)));

  p_keff_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    k_eff != '0);
endmodule

bind xor_entropy_harvester xor_entropy_harvester_chk #(.N_SRC(N_SRC), .KW(KW)) u_chk (
  .clk(clk), .rst(rst), .samp_en(samp_en), .cnt_q(cnt_q), .k_eff(k_eff),
  .cap_q(cap_q), .ser_data(ser_data), .ser_valid(ser_valid)
);

// File: tb/xor_entropy_harvester_bench.sv
`timescale 1ns/1ps
module xor_entropy_harvester_bench;
  localparam int unsigned N_SRC = 8;
  localparam int unsigned KW    = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_SRC-1:0] osc_in = '0;
  logic [KW-1:0]    div_k = KW'(3);
  logic             ser_data;
  logic             ser_valid;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xor_entropy_harvester #(.N_SRC(N_SRC), .KW(KW)) u_xor_entropy_harvester (
    .clk(clk), .rst(rst), .osc_in(osc_in), .div_k(div_k),
    .ser_data(ser_data), .ser_valid(ser_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errs = errs + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errs = errs + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance until a strobe is seen; returns cycles taken.
  task automatic wait_valid(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!ser_valid && n < 1000);
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    osc_in = '1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R1 valid in reset", ser_valid, 0);
      chk("R1 data in reset", ser_data, 0);
    end
    rst = 1'b0;
    tick();
    chk("R1 first strobe after release", ser_valid, 1);
    osc_in = '0;
  endtask

  task automatic t_period_r2(input int k);
    int n;
    div_k = KW'(k);
    wait_valid(n);
    wait_valid(n);
    for (int p = 0; p < 3; p++) begin
      wait_valid(n);
      chk("R2 strobe spacing", n, k);
    end
    tick();
    chk("R2 strobe one cycle wide", ser_valid, 0);
  endtask

  task automatic t_kzero_r3();
    int n;
    div_k = '0;
    wait_valid(n);
    wait_valid(n);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R3 k=0 strobe every cycle", ser_valid, 1);
    end
  endtask

  task automatic t_data_r4(input logic [N_SRC-1:0] pat);
    int n;
    osc_in = pat;
    for (int i = 0; i < 5; i++) tick();
    wait_valid(n);
    chk("R4 data is xor of sources", ser_data, ^pat);
  endtask

  task automatic t_hold_r5();
    int n;
    logic held;
    div_k = KW'(8);
    osc_in = 8'h01;
    for (int i = 0; i < 12; i++) tick();
    wait_valid(n);
    held = ser_data;
    osc_in = 8'h00;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (!ser_valid) chk("R5 data held between strobes", ser_data, held);
    end
  endtask

  task automatic t_each_r6();
    int n;
    logic [N_SRC-1:0] base;
    div_k = KW'(3);
    base = 8'h5A;
    for (int b = 0; b < N_SRC; b++) begin
      logic [N_SRC-1:0] pat;
      pat = base ^ (N_SRC'(1) << b);
      osc_in = pat;
      for (int i = 0; i < 5; i++) tick();
      wait_valid(n);
      chk("R6 single source flips output", ser_data, ~(^base) & 1'b1);
    end
  endtask

  task automatic t_change_r7();
    int n;
    div_k = KW'(6);
    wait_valid(n);
    wait_valid(n);
    div_k = KW'(2);
    wait_valid(n);
    chk("R7 old K finishes current gap", n, 6);
    wait_valid(n);
    chk("R7 new K used next gap", n, 2);
  endtask

  initial begin
    t_reset_r1();
    t_period_r2(4);
    t_period_r2(7);
    t_kzero_r3();
    div_k = KW'(1);
    begin
      int n;
      wait_valid(n);
      tick();
      chk("R3 k=1 strobe every cycle", ser_valid, 1);
    end
    div_k = KW'(3);
    t_data_r4(8'h00);
    t_data_r4(8'h01);
    t_data_r4(8'hC3);
    t_data_r4(8'hFE);
    t_hold_r5();
    t_each_r6();
    t_change_r7();   // also exercises reload behaviour of R8
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule